// File: doc/BRIEF.md
# Operand Forwarding Select and Load-Use Stall Logic

This block is the purely combinational hazard resolver for a five-stage, in-order integer pipeline. It runs while an instruction sits in decode. It compares that instruction's two source register numbers with the destination numbers of the two older instructions, one in the decode/execute register and one in the execute/memory register. From these comparisons it produces one 2-bit bypass select for each ALU operand. The selects are registered together with the instruction and steer the operand muxes one cycle later.

The same comparisons also detect a load whose result is needed by the very next instruction. In that case the block holds the program counter and the fetch/decode register, and asks for the control fields entering execute to be zeroed. This sends a single no-op bubble down the pipe. The load itself advances. One cycle later, the load sits in the execute/memory stage and its data reaches the stalled instruction over the far bypass path.

Top module: `hazard_unit`

## Requirements
- R1: Each operand select is one of three codes: 2'b00 takes the operand from the register file, 2'b01 takes the result of the immediately older instruction, and 2'b10 takes the load data or ALU result of the instruction two ahead. Code 2'b11 never appears.
- R2: Operand A select is 2'b01 when the decode source A equals the decode/execute destination, that destination is nonzero, and its register-write flag is 1.
- R3: When R2 does not apply, operand A select is 2'b10 when source A equals the nonzero execute/memory destination and that stage's register-write flag is 1. Otherwise it is 2'b00.
- R4: When both older instructions write the register that source A reads, the nearer one (decode/execute) is selected, giving 2'b01.
- R5: Operand B select follows R2 to R4 using decode source B, independently of operand A.
- R6: Register number 0 never matches, either for forwarding or for stalling, whatever the write or load flags are.
- R7: A stall is raised when the decode/execute memory-read flag is 1, its destination is nonzero, and the destination equals source A or source B. This holds whatever its register-write flag is. During a stall, pc_we_o and ifid_we_o are 0 and bubble_o is 1.
- R8: A load in decode/execute whose destination matches neither source does not stall.
- R9: With no load-use hazard, pc_we_o and ifid_we_o are 1 and bubble_o is 0.
- R10: In the cycle after a stall, the bubble (all flags 0) sits in decode/execute and the load sits in execute/memory. The stall drops and the waiting operand selects 2'b10, so the dependent instruction is delayed by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a_i | input | REG_AW | First source register number of the decoding instruction |
| dec_src_b_i | input | REG_AW | Second source register number of the decoding instruction |
| ex_dst_i | input | REG_AW | Destination register number held in decode/execute |
| ex_wr_i | input | 1 | Register-write flag held in decode/execute |
| ex_load_i | input | 1 | Memory-read flag held in decode/execute |
| mem_dst_i | input | REG_AW | Destination register number held in execute/memory |
| mem_wr_i | input | 1 | Register-write flag held in execute/memory |
| fwd_a_o | output | 2 | Bypass select for ALU operand A |
| fwd_b_o | output | 2 | Bypass select for ALU operand B |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Zeroes the control fields written into decode/execute |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus and no register lies between them. The bench applies each vector just after a rising edge and samples the outputs 2 ns later, before the falling edge. This keeps both the driving and the sampling clear of the active edge. The one-cycle delay of R10 is a two-step sequence. The bench first applies the load-use pattern, then on the next cycle applies the state the surrounding pipeline would hold after the bubble, and checks each step in its own cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF   = 2'b00,
    FWD_NEAR = 2'b01,
    FWD_FAR  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0]   src_i,
  input  logic [REG_AW-1:0]   near_dst_i,
  input  logic                near_wr_i,
  input  logic [REG_AW-1:0]   far_dst_i,
  input  logic                far_wr_i,
  output hazard_pkg::fwd_sel_e sel_o
);
  import hazard_pkg::*;

  logic near_hit, far_hit;

  assign near_hit = near_wr_i && (near_dst_i != '0) && (near_dst_i == src_i);
  assign far_hit  = far_wr_i  && (far_dst_i  != '0) && (far_dst_i  == src_i);

  // nearer producer has priority
  always_comb begin
    if (near_hit)     sel_o = FWD_NEAR;
    else if (far_hit) sel_o = FWD_FAR;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_a_i,
  input  logic [REG_AW-1:0] src_b_i,
  input  logic [REG_AW-1:0] ld_dst_i,
  input  logic              ld_i,
  output logic              stall_o
);
  logic dst_live;

  assign dst_live = ld_i && (ld_dst_i != '0);
  assign stall_o  = dst_live && ((ld_dst_i == src_a_i) || (ld_dst_i == src_b_i));
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] dec_src_a_i,
  input  logic [REG_AW-1:0] dec_src_b_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_wr_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wr_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              bubble_o
);
  import hazard_pkg::*;

  localparam int unsigned NUM_SRC = 2;

  logic [REG_AW-1:0] src [NUM_SRC];
  fwd_sel_e          sel [NUM_SRC];
  logic              stall;

  assign src[0] = dec_src_a_i;
  assign src[1] = dec_src_b_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src_i      (src[g]),
      .near_dst_i (ex_dst_i),
      .near_wr_i  (ex_wr_i),
      .far_dst_i  (mem_dst_i),
      .far_wr_i   (mem_wr_i),
      .sel_o      (sel[g])
    );
  end

  load_use_detect #(.REG_AW(REG_AW)) u_ldu (
    .src_a_i  (dec_src_a_i),
    .src_b_i  (dec_src_b_i),
    .ld_dst_i (ex_dst_i),
    .ld_i     (ex_load_i),
    .stall_o  (stall)
  );

  assign fwd_a_o   = sel[0];
  assign fwd_b_o   = sel[1];
  assign pc_we_o   = ~stall;
  assign ifid_we_o = ~stall;
  assign bubble_o  = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] dec_src_a_i,
  input logic [REG_AW-1:0] dec_src_b_i,
  input logic [REG_AW-1:0] ex_dst_i,
  input logic              ex_wr_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_dst_i,
  input logic              mem_wr_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              pc_we_o,
  input logic              ifid_we_o,
  input logic              bubble_o
);
  always_comb begin
    p_no_code3_r1: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)
      else $error("select code 3 produced");
    p_near_wins_r4: assert (!(ex_wr_i && ex_dst_i != '0 && ex_dst_i == dec_src_a_i) || fwd_a_o == 2'b01)
      else $error("nearer producer not chosen for A");
    p_near_b_r5: assert (!(ex_wr_i && ex_dst_i != '0 && ex_dst_i == dec_src_b_i) || fwd_b_o == 2'b01)
      else $error("nearer producer not chosen for B");
    p_zero_src_r6: assert (dec_src_a_i != '0 || fwd_a_o == 2'b00)
      else $error("register 0 forwarded");
    p_stall_needs_load_r7: assert (!bubble_o || (ex_load_i && ex_dst_i != '0))
      else $error("bubble without load");
    p_hold_pair_r9: assert (pc_we_o == ifid_we_o && bubble_o == !pc_we_o)
      else $error("stall controls disagree");
  end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_AW(REG_AW)) chk_i (
  .dec_src_a_i (dec_src_a_i),
  .dec_src_b_i (dec_src_b_i),
  .ex_dst_i    (ex_dst_i),
  .ex_wr_i     (ex_wr_i),
  .ex_load_i   (ex_load_i),
  .mem_dst_i   (mem_dst_i),
  .mem_wr_i    (mem_wr_i),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o),
  .pc_we_o     (pc_we_o),
  .ifid_we_o   (ifid_we_o),
  .bubble_o    (bubble_o)
);

// File: tb/hazard_unit_tb_top.sv
`timescale 1ns/1ps
module hazard_unit_tb_top;
  localparam int unsigned AW = 5;
  localparam int NV = 15;
  // {src_a, src_b, ex_dst, ex_wr, ex_load, mem_dst, mem_wr, exp_a, exp_b, exp_stall}
  localparam logic [27:0] VEC [NV] = '{
    {5'd1, 5'd2, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 1'b0}, // R9 idle
    {5'd3, 5'd4, 5'd3,  1'b1, 1'b0, 5'd9,  1'b1, 2'b01, 2'b00, 1'b0}, // R2
    {5'd3, 5'd4, 5'd9,  1'b1, 1'b0, 5'd3,  1'b1, 2'b10, 2'b00, 1'b0}, // R3
    {5'd3, 5'd4, 5'd3,  1'b1, 1'b0, 5'd3,  1'b1, 2'b01, 2'b00, 1'b0}, // R4
    {5'd5, 5'd6, 5'd7,  1'b1, 1'b0, 5'd6,  1'b1, 2'b00, 2'b10, 1'b0}, // R5
    {5'd6, 5'd6, 5'd6,  1'b1, 1'b0, 5'd6,  1'b1, 2'b01, 2'b01, 1'b0}, // R5 R4
    {5'd0, 5'd0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 2'b00, 2'b00, 1'b0}, // R6
    {5'd3, 5'd4, 5'd3,  1'b0, 1'b0, 5'd3,  1'b1, 2'b10, 2'b00, 1'b0}, // R3 near off
    {5'd3, 5'd4, 5'd3,  1'b0, 1'b0, 5'd3,  1'b0, 2'b00, 2'b00, 1'b0}, // R3 both off
    {5'd8, 5'd9, 5'd8,  1'b1, 1'b1, 5'd0,  1'b0, 2'b01, 2'b00, 1'b1}, // R7 via A
    {5'd8, 5'd9, 5'd9,  1'b1, 1'b1, 5'd0,  1'b0, 2'b00, 2'b01, 1'b1}, // R7 via B
    {5'd8, 5'd9, 5'd10, 1'b1, 1'b1, 5'd8,  1'b1, 2'b10, 2'b00, 1'b0}, // R8
    {5'd0, 5'd0, 5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 2'b00, 2'b00, 1'b0}, // R6 load r0
    {5'd4, 5'd5, 5'd4,  1'b0, 1'b1, 5'd0,  1'b0, 2'b00, 2'b00, 1'b1}, // R7 wr flag 0
    {5'd31,5'd30,5'd30, 1'b1, 1'b0, 5'd31, 1'b1, 2'b10, 2'b01, 1'b0}  // R5 R3 top regs
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] src_a, src_b, ex_dst, mem_dst;
  logic ex_wr, ex_load, mem_wr;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, bubble;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hazard_unit #(.REG_AW(AW)) dut_i (
    .dec_src_a_i (src_a), .dec_src_b_i (src_b),
    .ex_dst_i (ex_dst), .ex_wr_i (ex_wr), .ex_load_i (ex_load),
    .mem_dst_i (mem_dst), .mem_wr_i (mem_wr),
    .fwd_a_o (fwd_a), .fwd_b_o (fwd_b),
    .pc_we_o (pc_we), .ifid_we_o (ifid_we), .bubble_o (bubble)
  );

  task automatic drive(input logic [27:0] v);
    @(posedge clk);
    #1;
    {src_a, src_b, ex_dst, ex_wr, ex_load, mem_dst, mem_wr} = v[27:5];
    #1;
  endtask

  task automatic check(input string req, input logic [1:0] ea, input logic [1:0] eb, input logic st);
    logic [6:0] got, exp;
    got = {fwd_a, fwd_b, pc_we, ifid_we, bubble};
    exp = {ea, eb, ~st, ~st, st};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  initial begin
    {src_a, src_b, ex_dst, ex_wr, ex_load, mem_dst, mem_wr} = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset", 2'b00, 2'b00, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("R1 vec%0d", i), VEC[i][4:3], VEC[i][2:1], VEC[i][0]);
    end
    // R10: load-use, then next cycle bubble in ID/EX and load in EX/MEM
    drive({5'd12, 5'd2, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0});
    check("R10 stall step", 2'b01, 2'b00, 1'b1);
    drive({5'd12, 5'd2, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 5'd0});
    check("R10 release step", 2'b10, 2'b00, 1'b0);
    // R6: nonzero flags with r0 as a producer, nonzero source
    drive({5'd7, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0});
    check("R6 r0 producer", 2'b00, 2'b00, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule